// File: doc/BRIEF.md
# Segment Access Limit and Rights Checker

This block vets each memory access against the descriptor cached for the segment register the access uses. It then forms the linear address. The requester presents the following in one cycle:

- a 32-bit offset;
- an access kind (read, write or instruction fetch);
- an access length in bytes;
- the cached descriptor fields: base, 20-bit limit, granularity flag, present flag and the 4-bit type field of a non-system segment.

One clock later the block returns four results:

- the linear address;
- a response strobe;
- a fault flag with a 2-bit cause;
- a request to write the accessed flag back into the descriptor.

The block sits between address generation and paging. Descriptor loading, privilege comparison and page translation are handled elsewhere. Checks apply in a fixed priority. An absent segment wins over everything else. A rights violation wins over a range violation. The block is purely combinational between its input sample and one output register stage, so a new access may be issued every cycle.

Top module: `seg_access_check`

## Requirements
- R1: One cycle after a cycle with `req_valid` high, `rsp_valid` is high and `rsp_lin` equals `desc_base + req_offset` modulo 2^32, whether or not the access faults.
- R2: With `desc_gran`=0 the effective limit is the 20-bit limit in bytes. With `desc_gran`=1 it is the limit shifted left by 12 with the low 12 bits set to one.
- R3: For an expand-up segment the last byte (offset + length - 1, computed without wrap) must not exceed the effective limit, otherwise cause 2 (range) is reported. A length of 0 is treated as 1.
- R4: For a data segment with type bit 2 set (expand-down), the offset must be strictly above the effective limit and the last byte must not pass 2^32-1, otherwise cause 2 is reported.
- R5: When `desc_present` is 0 the access faults with cause 1 (absent), whatever its kind, range or type.
- R6: A write (`req_kind`=1) to a code segment (type bit 3 = 1) or to a data segment with type bit 1 = 0 faults with cause 3 (rights).
- R7: A read (`req_kind`=0 or 3) of a code segment with type bit 1 = 0 faults with cause 3. A fetch (`req_kind`=2) from a data segment faults with cause 3. A fetch from any code segment is allowed.
- R8: When both a rights and a range violation exist on a present segment, cause 3 is reported.
- R9: `acc_set` is high in the response cycle exactly when the access did not fault and type bit 0 (accessed) was 0.
- R10: During reset, and one cycle after a cycle with `req_valid` low, `rsp_valid`, `rsp_fault`, `rsp_cause` and `acc_set` are all zero. `rsp_fault` is high exactly when `rsp_cause` is nonzero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Access request this cycle |
| req_kind | input | 2 | 0 read, 1 write, 2 fetch, 3 read |
| req_len | input | 3 | Access length in bytes (0 treated as 1) |
| req_offset | input | 32 | Offset within the segment |
| desc_base | input | 32 | Cached segment base |
| desc_limit | input | 20 | Cached limit field |
| desc_gran | input | 1 | Limit unit: 0 bytes, 1 4-KiB pages |
| desc_present | input | 1 | Segment present |
| desc_type | input | 4 | Type: [3] code, [2] expand-down/conforming, [1] writable/readable, [0] accessed |
| rsp_valid | output | 1 | Response for the previous cycle's request |
| rsp_lin | output | 32 | Linear address |
| rsp_fault | output | 1 | Access faulted |
| rsp_cause | output | 2 | 0 none, 1 absent, 2 range, 3 rights |
| acc_set | output | 1 | Request to set the accessed flag |

## Verification
Expand-up accesses are placed on both sides of the last permitted byte, in byte and in page granularity. This distinguishes an off-by-one limit and a missing scaling of the low 12 bits. Expand-down cases probe the offset equal to the limit, the first byte above it, and accesses that run past the top of the address space. These cases separate the inverted comparison from the plain one. Every kind is crossed with the writable/readable and code bits, and with combinations of violations, to pin down the permission table and the cause priority. Accessed-flag cases compare a clean access, a faulting access and an already-set flag, and the linear address is checked against a base that wraps past 2^32.

// File: rtl/segchk_pkg.sv
package segchk_pkg;
  typedef enum logic [1:0] {
    ACC_READ  = 2'd0,
    ACC_WRITE = 2'd1,
    ACC_FETCH = 2'd2,
    ACC_RSVD  = 2'd3
  } acc_kind_e;

  typedef enum logic [1:0] {
    FLT_NONE   = 2'd0,
    FLT_ABSENT = 2'd1,
    FLT_RANGE  = 2'd2,
    FLT_RIGHTS = 2'd3
  } flt_cause_e;

  // bit positions inside the type nibble
  localparam int TB_CODE = 3;
  localparam int TB_DIR  = 2;
  localparam int TB_PERM = 1;
  localparam int TB_ACC  = 0;
endpackage

// File: rtl/segchk_limit.sv
module segchk_limit #(
  parameter int AW   = 32,
  parameter int LW   = 20,
  parameter int GSH  = 12,
  parameter int LENW = 3
) (
  input  logic [AW-1:0]   offset,
  input  logic [LENW-1:0] len,
  input  logic [LW-1:0]   limit,
  input  logic            gran,
  input  logic            expand_down,
  output logic            in_range
);
  localparam int EW = AW + 1;

  logic [AW-1:0]   scaled;
  logic [LENW-1:0] span;
  logic [EW-1:0]   last;

  always_comb begin
    if (gran) scaled = AW'({limit, {GSH{1'b1}}});
    else      scaled = AW'(limit);
    span = (len == '0) ? '0 : len - 1'b1;
    last = {1'b0, offset} + EW'(span);
    if (expand_down) in_range = (offset > scaled) && !last[AW];
    else             in_range = (last <= {1'b0, scaled});
  end
endmodule

// File: rtl/segchk_rights.sv
module segchk_rights
  import segchk_pkg::*;
(
  input  acc_kind_e  kind,
  input  logic [3:0] tnib,
  output logic       denied
);
  always_comb begin
    unique case (kind)
      ACC_WRITE: denied = tnib[TB_CODE] | ~tnib[TB_PERM];
      ACC_FETCH: denied = ~tnib[TB_CODE];
      default:   denied = tnib[TB_CODE] & ~tnib[TB_PERM];
    endcase
  end
endmodule

// File: rtl/seg_access_check.sv
module seg_access_check
  import segchk_pkg::*;
#(
  parameter int AW   = 32,
  parameter int LW   = 20,
  parameter int GSH  = 12,
  parameter int LENW = 3
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            req_valid,
  input  logic [1:0]      req_kind,
  input  logic [LENW-1:0] req_len,
  input  logic [AW-1:0]   req_offset,
  input  logic [AW-1:0]   desc_base,
  input  logic [LW-1:0]   desc_limit,
  input  logic            desc_gran,
  input  logic            desc_present,
  input  logic [3:0]      desc_type,
  output logic            rsp_valid,
  output logic [AW-1:0]   rsp_lin,
  output logic            rsp_fault,
  output logic [1:0]      rsp_cause,
  output logic            acc_set
);
  acc_kind_e  kind;
  logic       in_range;
  logic       denied;
  logic       exdn;
  flt_cause_e cause_nx;
  logic [AW-1:0] lin_nx;
  logic       acc_nx;

  assign kind = acc_kind_e'(req_kind);
  assign exdn = ~desc_type[TB_CODE] & desc_type[TB_DIR];

  segchk_limit #(.AW(AW), .LW(LW), .GSH(GSH), .LENW(LENW)) u_lim (
    .offset      (req_offset),
    .len         (req_len),
    .limit       (desc_limit),
    .gran        (desc_gran),
    .expand_down (exdn),
    .in_range    (in_range)
  );

  segchk_rights u_rgt (
    .kind   (kind),
    .tnib   (desc_type),
    .denied (denied)
  );

  // next-state
  always_comb begin
    lin_nx = desc_base + req_offset;
    if (!req_valid)        cause_nx = FLT_NONE;
    else if (!desc_present) cause_nx = FLT_ABSENT;
    else if (denied)       cause_nx = FLT_RIGHTS;
    else if (!in_range)    cause_nx = FLT_RANGE;
    else                   cause_nx = FLT_NONE;
    acc_nx = req_valid && (cause_nx == FLT_NONE) && !desc_type[TB_ACC];
  end

  // registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rsp_valid <= 1'b0;
      rsp_fault <= 1'b0;
      rsp_cause <= 2'd0;
      acc_set   <= 1'b0;
    end else begin
      rsp_valid <= req_valid;
      rsp_fault <= (cause_nx != FLT_NONE);
      rsp_cause <= cause_nx;
      acc_set   <= acc_nx;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)         rsp_lin <= '0;
    else if (req_valid) rsp_lin <= lin_nx;
  end
endmodule

// File: rtl/segchk_sva.sv
module segchk_sva #(
  parameter int AW   = 32,
  parameter int LW   = 20,
  parameter int LENW = 3
) (
  input logic            clk,
  input logic            rst_n,
  input logic            req_valid,
  input logic [1:0]      req_kind,
  input logic [LENW-1:0] req_len,
  input logic [AW-1:0]   req_offset,
  input logic [AW-1:0]   desc_base,
  input logic [LW-1:0]   desc_limit,
  input logic            desc_gran,
  input logic            desc_present,
  input logic [3:0]      desc_type,
  input logic            rsp_valid,
  input logic [AW-1:0]   rsp_lin,
  input logic            rsp_fault,
  input logic [1:0]      rsp_cause,
  input logic            acc_set
);
  a_r1_lin_sum: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid |=> rsp_valid && (rsp_lin == AW'($past(desc_base) + $past(req_offset))));

  a_r5_absent: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid && !desc_present |=> rsp_fault && rsp_cause == 2'd1);

  a_r6_code_write: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid && desc_present && req_kind == 2'd1 && desc_type[3] |=> rsp_cause == 2'd3);

  a_r7_fetch_data: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid && desc_present && req_kind == 2'd2 && !desc_type[3] |=> rsp_cause == 2'd3);

  a_r9_acc_clean: assert property (@(posedge clk) disable iff (!rst_n)
    acc_set |-> rsp_valid && !rsp_fault);

  a_r10_idle: assert property (@(posedge clk) disable iff (!rst_n)
    !req_valid |=> !rsp_valid && !rsp_fault && rsp_cause == 2'd0 && !acc_set);
endmodule

bind seg_access_check segchk_sva #(.AW(AW), .LW(LW), .LENW(LENW)) u_sva (.*);

// File: tb/sim_seg_access_check.sv
module sim_seg_access_check;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0;
  logic [1:0]  req_kind = '0;
  logic [2:0]  req_len = '0;
  logic [31:0] req_offset = '0;
  logic [31:0] desc_base = '0;
  logic [19:0] desc_limit = '0;
  logic        desc_gran = 1'b0;
  logic        desc_present = 1'b0;
  logic [3:0]  desc_type = '0;
  logic        rsp_valid;
  logic [31:0] rsp_lin;
  logic        rsp_fault;
  logic [1:0]  rsp_cause;
  logic        acc_set;

  int n_run = 0;
  int n_fail = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  seg_access_check u0 (.*);

  typedef struct packed {
    logic [1:0]  kind;
    logic [2:0]  len;
    logic [31:0] base;
    logic [19:0] limit;
    logic        gran;
    logic        pres;
    logic [3:0]  typ;
    logic [31:0] off;
    logic [1:0]  cause;
    logic        acc;
  } vec_t;

  localparam int NV = 21;
  localparam vec_t VT [NV] = '{
    '{2'd0, 3'd4, 32'h0000_1000, 20'h000FF, 1'b0, 1'b1, 4'h3, 32'h0000_00FC, 2'd0, 1'b0}, // R3 last byte at limit
    '{2'd0, 3'd4, 32'h0000_1000, 20'h000FF, 1'b0, 1'b1, 4'h3, 32'h0000_00FD, 2'd2, 1'b0}, // R3 one past
    '{2'd1, 3'd2, 32'h0000_2000, 20'h0FFFF, 1'b0, 1'b1, 4'h1, 32'h0000_0010, 2'd3, 1'b0}, // R6 read-only data
    '{2'd0, 3'd1, 32'h0000_0000, 20'h00001, 1'b1, 1'b1, 4'h3, 32'h0000_1FFF, 2'd0, 1'b0}, // R2 page top
    '{2'd0, 3'd1, 32'h0000_0000, 20'h00001, 1'b1, 1'b1, 4'h3, 32'h0000_2000, 2'd2, 1'b0}, // R2 beyond
    '{2'd0, 3'd1, 32'h0000_5000, 20'h0FFFF, 1'b0, 1'b0, 4'h3, 32'h0000_0000, 2'd1, 1'b0}, // R5
    '{2'd1, 3'd1, 32'h0000_0000, 20'h00FFF, 1'b0, 1'b1, 4'h7, 32'h0000_0FFF, 2'd2, 1'b0}, // R4 at limit
    '{2'd1, 3'd1, 32'h0000_0000, 20'h00FFF, 1'b0, 1'b1, 4'h7, 32'h0000_1000, 2'd0, 1'b0}, // R4 above limit
    '{2'd2, 3'd4, 32'h0000_0000, 20'hFFFFF, 1'b1, 1'b1, 4'h3, 32'h0000_0040, 2'd3, 1'b0}, // R7 fetch data
    '{2'd1, 3'd4, 32'h0000_0000, 20'hFFFFF, 1'b1, 1'b1, 4'hB, 32'h0000_0040, 2'd3, 1'b0}, // R6 write code
    '{2'd0, 3'd4, 32'h0000_0000, 20'hFFFFF, 1'b1, 1'b1, 4'h9, 32'h0000_0040, 2'd3, 1'b0}, // R7 exec-only read
    '{2'd2, 3'd4, 32'h0000_0000, 20'hFFFFF, 1'b1, 1'b1, 4'h9, 32'h0000_0040, 2'd0, 1'b0}, // R7 exec-only fetch
    '{2'd0, 3'd4, 32'hFFFF_F000, 20'hFFFFF, 1'b1, 1'b1, 4'h2, 32'h0000_2000, 2'd0, 1'b1}, // R1 wrap, R9
    '{2'd1, 3'd2, 32'h0000_0000, 20'hFFFFF, 1'b1, 1'b1, 4'h7, 32'h0000_1234, 2'd2, 1'b0}, // R4 full limit
    '{2'd1, 3'd1, 32'h0000_0000, 20'h00000, 1'b0, 1'b0, 4'hB, 32'h0000_0000, 2'd1, 1'b0}, // R5 over rights
    '{2'd1, 3'd4, 32'h0000_0000, 20'h000FF, 1'b0, 1'b1, 4'h1, 32'h0000_0500, 2'd3, 1'b0}, // R8
    '{2'd0, 3'd4, 32'h0000_0000, 20'hFFFFF, 1'b1, 1'b1, 4'h3, 32'hFFFF_FFFE, 2'd2, 1'b0}, // R3 wrap
    '{2'd0, 3'd2, 32'h0000_0000, 20'h000FF, 1'b0, 1'b1, 4'h2, 32'h0000_0200, 2'd2, 1'b0}, // R9 no set on fault
    '{2'd2, 3'd2, 32'h0000_0100, 20'h000FF, 1'b0, 1'b1, 4'hA, 32'h0000_0010, 2'd0, 1'b1}, // R9 code fetch
    '{2'd1, 3'd4, 32'h0000_0000, 20'h0FFFF, 1'b0, 1'b1, 4'h6, 32'hFFFF_FFFC, 2'd0, 1'b1}, // R4 top ok
    '{2'd1, 3'd4, 32'h0000_0000, 20'h0FFFF, 1'b0, 1'b1, 4'h6, 32'hFFFF_FFFE, 2'd2, 1'b0}  // R4 past top
  };

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_run++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic chk_idle(input string tag);
    chk(rsp_valid == 1'b0, tag, 32'(rsp_valid), 32'd0);
    chk(rsp_fault == 1'b0 && rsp_cause == 2'd0, tag, {29'd0, rsp_fault, rsp_cause}, 32'd0);
    chk(acc_set == 1'b0, tag, 32'(acc_set), 32'd0);
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  endtask

  initial begin
    #(4 * 200000);
    n_run++;
    n_fail++;
    $display("FAIL watchdog actual=%h expected=%h", 32'd1, 32'd0);
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    chk_idle("R10 reset");
    chk(rsp_lin == 32'd0, "R10 reset lin", rsp_lin, 32'd0);
    rst_n = 1'b1;
    @(negedge clk);
    chk_idle("R10 after release");

    for (int i = 0; i < NV; i++) begin
      req_valid    = 1'b1;
      req_kind     = VT[i].kind;
      req_len      = VT[i].len;
      req_offset   = VT[i].off;
      desc_base    = VT[i].base;
      desc_limit   = VT[i].limit;
      desc_gran    = VT[i].gran;
      desc_present = VT[i].pres;
      desc_type    = VT[i].typ;
      @(negedge clk);
      chk(rsp_valid == 1'b1, $sformatf("R1 valid v%0d", i), 32'(rsp_valid), 32'd1);
      chk(rsp_lin == VT[i].base + VT[i].off, $sformatf("R1 lin v%0d", i), rsp_lin, VT[i].base + VT[i].off);
      chk(rsp_cause == VT[i].cause, $sformatf("R2-R8 cause v%0d", i), 32'(rsp_cause), 32'(VT[i].cause));
      chk(rsp_fault == (VT[i].cause != 2'd0), $sformatf("R10 fault flag v%0d", i), 32'(rsp_fault), 32'(VT[i].cause != 2'd0));
      chk(acc_set == VT[i].acc, $sformatf("R9 acc v%0d", i), 32'(acc_set), 32'(VT[i].acc));
    end

    // idle cycle after a request: response drops, address holds
    req_valid = 1'b0;
    req_offset = 32'h1234_5678;
    @(negedge clk);
    chk_idle("R10 idle");

    // length 0 behaves as length 1 at the last byte
    req_valid = 1'b1; req_kind = 2'd0; req_len = 3'd0; req_offset = 32'h0000_00FF;
    desc_base = 32'h10; desc_limit = 20'h000FF; desc_gran = 1'b0; desc_present = 1'b1; desc_type = 4'h3;
    @(negedge clk);
    chk(rsp_cause == 2'd0, "R3 zero length", 32'(rsp_cause), 32'd0);
    chk(rsp_lin == 32'h10F, "R1 zero length lin", rsp_lin, 32'h10F);

    // reserved kind acts as read of a readable code segment
    req_kind = 2'd3; req_len = 3'd1; req_offset = 32'h0; desc_type = 4'hB;
    @(negedge clk);
    chk(rsp_cause == 2'd0, "R7 kind 3 as read", 32'(rsp_cause), 32'd0);

    // reset in the middle of traffic clears the response
    req_kind = 2'd1; desc_type = 4'h1;
    #1 rst_n = 1'b0;
    @(negedge clk);
    chk_idle("R10 mid reset");
    req_valid = 1'b0;
    rst_n = 1'b1;
    @(negedge clk);
    chk_idle("R10 post reset");

    finish_run();
  end
endmodule